// File: doc/BRIEF.md
# Single-Cycle Six-Instruction Processor Core

A 32-bit processor core in which every instruction is fetched, decoded, executed and retired within one clock cycle. It runs a six-instruction subset: two register-register arithmetic operations, an OR with a zero-extended immediate, a word load, a word store and a branch-if-equal. The core contains the program counter, a 32 by 32-bit register file, an immediate extender, an ALU that can add, subtract and OR, and a main decoder. The decoder drives the datapath multiplexers through a fixed set of control fields: destination select, extend mode, operand B select, ALU operation, memory write, writeback source and register write.

Instruction memory and data memory are ideal arrays inside the core. Reads are combinational from the address, and writes take effect on the clock edge. While reset is held, a load port writes words into either array, so a program and its data can be placed before execution starts. The core exposes the current PC and fetched instruction, its register-writeback strobe, address and data, and its data-memory write strobe, address and data. These show what each instruction did in the cycle it ran.

Top module: `sc6_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 and every register becomes 0. The first instruction after reset is fetched from word 0, and it reads zeros from the register file.
- R2: Opcode 0x00 with funct 0x21 writes rs+rt into rd, and funct 0x23 writes rs-rt into rd. Both wrap modulo 2^32. Fields: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0].
- R3: Opcode 0x0D writes rs OR the zero-extended imm16 (bits [15:0]) into rt.
- R4: Opcode 0x23 loads rt from the data word at rs + sign-extended imm16. The word index is taken from address bits above bit 1.
- R5: Opcode 0x2B stores rt to the data word at rs + sign-extended imm16. `dm_we_o` is high only for this opcode, and a later load from the same address returns the stored value.
- R6: Opcode 0x04 with rs equal to rt sets the next PC to PC+4 plus the sign-extended imm16 shifted left by two. This covers negative offsets.
- R7: Every instruction other than a taken branch sets the next PC to PC+4. This includes a branch whose registers differ.
- R8: Register 0 always reads as zero. An instruction that targets it writes nothing, and `rf_we_o` stays low.
- R9: Any other opcode, and opcode 0x00 with any other funct, writes no register and no memory and advances the PC by 4.
- R10: While `rst` is high and `ld_we` is high, `ld_data` is written at word `ld_addr`. It goes to instruction memory when `ld_dmem` is 0 and to data memory when `ld_dmem` is 1. The fetched word appears on `instr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; also enables the load port |
| ld_we | input | 1 | Load port write strobe (honoured only in reset) |
| ld_dmem | input | 1 | Load target: 0 instruction memory, 1 data memory |
| ld_addr | input | 6 | Load word index |
| ld_data | input | 32 | Load word |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction fetched at the PC |
| rf_we_o | output | 1 | Register write taking effect this cycle |
| rf_waddr_o | output | 5 | Destination register |
| rf_wdata_o | output | 32 | Writeback value |
| dm_we_o | output | 1 | Data memory write taking effect this cycle |
| dm_addr_o | output | 32 | Computed data address |
| dm_wdata_o | output | 32 | Store data |

## Verification
The properties are checked only after reset is released, and they assume that the fetched word is defined. The stimulus therefore fills every instruction and data word through the load port before execution begins. The branch-target property applies only when both register fields of a branch are equal, because the register values are not visible at the ports. The program therefore uses such a branch as its final spin loop. All data addresses the program forms are word-aligned and fall inside the data array, so the bench model can index the same word the core does.

// File: rtl/sc6_pkg.sv
package sc6_pkg;
   localparam logic [5:0] OP_RTYPE = 6'h00;
   localparam logic [5:0] OP_ORI   = 6'h0D;
   localparam logic [5:0] OP_LW    = 6'h23;
   localparam logic [5:0] OP_SW    = 6'h2B;
   localparam logic [5:0] OP_BEQ   = 6'h04;
   localparam logic [5:0] FN_ADDU  = 6'h21;
   localparam logic [5:0] FN_SUBU  = 6'h23;

   typedef enum logic [1:0] {
      ALU_ADD = 2'd0,
      ALU_SUB = 2'd1,
      ALU_OR  = 2'd2
   } alu_op_e;

   typedef struct packed {
      logic    dst_rd;    // 1: destination is rd, 0: rt
      logic    ext_sign;  // 1: sign-extend imm16, 0: zero-extend
      logic    src_imm;   // 1: ALU operand B is the immediate
      alu_op_e alu_op;
      logic    mem_wr;
      logic    wb_mem;    // 1: writeback from data memory
      logic    reg_wr;
      logic    is_beq;
   } ctrl_t;
endpackage

// File: rtl/sc6_ctrl.sv
module sc6_ctrl
   import sc6_pkg::*;
(
   input  logic [5:0] op,
   input  logic [5:0] fn,
   output ctrl_t      ctl
);
   always_comb begin
      ctl = '{dst_rd: 1'b0, ext_sign: 1'b0, src_imm: 1'b0, alu_op: ALU_ADD,
              mem_wr: 1'b0, wb_mem: 1'b0, reg_wr: 1'b0, is_beq: 1'b0};
      case (op)
         OP_RTYPE: begin
            if (fn == FN_ADDU || fn == FN_SUBU) begin
               ctl.dst_rd = 1'b1;
               ctl.reg_wr = 1'b1;
               ctl.alu_op = (fn == FN_SUBU) ? ALU_SUB : ALU_ADD;
            end
         end
         OP_ORI: begin
            ctl.src_imm = 1'b1;
            ctl.alu_op  = ALU_OR;
            ctl.reg_wr  = 1'b1;
         end
         OP_LW: begin
            ctl.ext_sign = 1'b1;
            ctl.src_imm  = 1'b1;
            ctl.wb_mem   = 1'b1;
            ctl.reg_wr   = 1'b1;
         end
         OP_SW: begin
            ctl.ext_sign = 1'b1;
            ctl.src_imm  = 1'b1;
            ctl.mem_wr   = 1'b1;
         end
         OP_BEQ: begin
            ctl.ext_sign = 1'b1;
            ctl.alu_op   = ALU_SUB;
            ctl.is_beq   = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/sc6_regfile.sv
module sc6_regfile #(
   parameter int XLEN = 32,
   parameter int NREG = 32,
   localparam int AW  = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [AW-1:0]   ra_a,
   input  logic [AW-1:0]   ra_b,
   input  logic            we,
   input  logic [AW-1:0]   wa,
   input  logic [XLEN-1:0] wd,
   output logic [XLEN-1:0] rd_a,
   output logic [XLEN-1:0] rd_b
);
   logic [XLEN-1:0] bank [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (i == 0) begin : g_zero
         assign bank[i] = '0;
      end else begin : g_flop
         logic [XLEN-1:0] r;
         always_ff @(posedge clk) begin
            if (rst)
               r <= '0;
            else if (we && wa == AW'(i))
               r <= wd;
         end
         assign bank[i] = r;
      end
   end

   assign rd_a = bank[ra_a];
   assign rd_b = bank[ra_b];
endmodule

// File: rtl/sc6_alu.sv
module sc6_alu
   import sc6_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  alu_op_e         op,
   output logic [XLEN-1:0] y,
   output logic            zero
);
   always_comb begin
      case (op)
         ALU_SUB: y = a - b;
         ALU_OR:  y = a | b;
         default: y = a + b;
      endcase
   end
   assign zero = (y == '0);
endmodule

// File: rtl/sc6_mem.sv
module sc6_mem #(
   parameter int XLEN  = 32,
   parameter int WORDS = 64,
   localparam int AW   = $clog2(WORDS)
) (
   input  logic            clk,
   input  logic            we,
   input  logic [AW-1:0]   waddr,
   input  logic [XLEN-1:0] wdata,
   input  logic [AW-1:0]   raddr,
   output logic [XLEN-1:0] rdata
);
   logic [XLEN-1:0] arr [WORDS];

   always_ff @(posedge clk) begin
      if (we)
         arr[waddr] <= wdata;
   end

   assign rdata = arr[raddr];
endmodule

// File: rtl/sc6_core.sv
module sc6_core
   import sc6_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int NREG     = 32,
   parameter int IM_WORDS = 64,
   parameter int DM_WORDS = 64,
   localparam int RAW     = $clog2(NREG),
   localparam int IAW     = $clog2(IM_WORDS),
   localparam int DAW     = $clog2(DM_WORDS),
   localparam int LAW     = (IAW > DAW) ? IAW : DAW
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            ld_we,
   input  logic            ld_dmem,
   input  logic [LAW-1:0]  ld_addr,
   input  logic [XLEN-1:0] ld_data,
   output logic [XLEN-1:0] pc_o,
   output logic [XLEN-1:0] instr_o,
   output logic            rf_we_o,
   output logic [RAW-1:0]  rf_waddr_o,
   output logic [XLEN-1:0] rf_wdata_o,
   output logic            dm_we_o,
   output logic [XLEN-1:0] dm_addr_o,
   output logic [XLEN-1:0] dm_wdata_o
);
   if (XLEN != 32) begin : g_bad_xlen
      $error("sc6_core: instruction encoding needs XLEN of 32");
   end
   if (NREG != 32) begin : g_bad_nreg
      $error("sc6_core: register fields are five bits, NREG must be 32");
   end
   if (IM_WORDS < 2 || (1 << IAW) != IM_WORDS) begin : g_bad_im
      $error("sc6_core: IM_WORDS must be a power of two of at least 2");
   end
   if (DM_WORDS < 2 || (1 << DAW) != DM_WORDS) begin : g_bad_dm
      $error("sc6_core: DM_WORDS must be a power of two of at least 2");
   end

   logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_tgt;
   logic [XLEN-1:0] instr;
   logic [5:0]      op, fn;
   logic [RAW-1:0]  f_rs, f_rt, f_rd, waddr;
   logic [15:0]     imm;
   logic [XLEN-1:0] ext, bus_a, bus_b, alu_b, alu_y, dm_rdata, wdata;
   logic            alu_zero, rf_we;
   ctrl_t           ctl;

   // program counter
   always_ff @(posedge clk) begin
      if (rst)
         pc_q <= '0;
      else
         pc_q <= pc_next;
   end

   // instruction memory: loader only
   sc6_mem #(.XLEN(XLEN), .WORDS(IM_WORDS)) u_imem (
      .clk   (clk),
      .we    (rst & ld_we & ~ld_dmem),
      .waddr (ld_addr[IAW-1:0]),
      .wdata (ld_data),
      .raddr (pc_q[IAW+1:2]),
      .rdata (instr)
   );

   assign op   = instr[31:26];
   assign f_rs = instr[25:21];
   assign f_rt = instr[20:16];
   assign f_rd = instr[15:11];
   assign imm  = instr[15:0];
   assign fn   = instr[5:0];

   sc6_ctrl u_ctrl (
      .op  (op),
      .fn  (fn),
      .ctl (ctl)
   );

   assign ext   = ctl.ext_sign ? {{(XLEN-16){imm[15]}}, imm} : {{(XLEN-16){1'b0}}, imm};
   assign waddr = ctl.dst_rd ? f_rd : f_rt;
   assign rf_we = ctl.reg_wr && (waddr != '0);

   sc6_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
      .clk  (clk),
      .rst  (rst),
      .ra_a (f_rs),
      .ra_b (f_rt),
      .we   (rf_we),
      .wa   (waddr),
      .wd   (wdata),
      .rd_a (bus_a),
      .rd_b (bus_b)
   );

   assign alu_b = ctl.src_imm ? ext : bus_b;

   sc6_alu #(.XLEN(XLEN)) u_alu (
      .a    (bus_a),
      .b    (alu_b),
      .op   (ctl.alu_op),
      .y    (alu_y),
      .zero (alu_zero)
   );

   // data memory: loader in reset, stores otherwise
   sc6_mem #(.XLEN(XLEN), .WORDS(DM_WORDS)) u_dmem (
      .clk   (clk),
      .we    (rst ? (ld_we & ld_dmem) : ctl.mem_wr),
      .waddr (rst ? ld_addr[DAW-1:0] : alu_y[DAW+1:2]),
      .wdata (rst ? ld_data : bus_b),
      .raddr (alu_y[DAW+1:2]),
      .rdata (dm_rdata)
   );

   assign wdata    = ctl.wb_mem ? dm_rdata : alu_y;
   assign pc_plus4 = pc_q + XLEN'(4);
   assign br_tgt   = pc_plus4 + {ext[XLEN-3:0], 2'b00};
   assign pc_next  = (ctl.is_beq && alu_zero) ? br_tgt : pc_plus4;

   assign pc_o       = pc_q;
   assign instr_o    = instr;
   assign rf_we_o    = rf_we;
   assign rf_waddr_o = waddr;
   assign rf_wdata_o = wdata;
   assign dm_we_o    = ctl.mem_wr;
   assign dm_addr_o  = alu_y;
   assign dm_wdata_o = bus_b;
endmodule

// File: rtl/sc6_core_chk.sv
module sc6_core_chk
   import sc6_pkg::*;
(
   input logic        clk,
   input logic        rst,
   input logic [5:0]  op,
   input logic [4:0]  rs,
   input logic [4:0]  rt,
   input logic [4:0]  rd,
   input logic [5:0]  fn,
   input logic [15:0] imm,
   input logic [31:0] pc,
   input logic        rf_we,
   input logic [4:0]  rf_waddr,
   input logic        dm_we
);
   logic legal;
   assign legal = (op == OP_RTYPE && (fn == FN_ADDU || fn == FN_SUBU)) ||
                  op == OP_ORI || op == OP_LW || op == OP_SW || op == OP_BEQ;

   // R7: anything but a branch moves on by one word
   a_r7_seq_pc: assert property (@(posedge clk) disable iff (rst)
      (op != OP_BEQ) |=> (pc == $past(pc) + 32'd4));

   // R6: a branch comparing a register with itself is always taken
   a_r6_self_branch: assert property (@(posedge clk) disable iff (rst)
      (op == OP_BEQ && rs == rt) |=>
      (pc == $past(pc) + 32'd4 + {{14{$past(imm[15])}}, $past(imm), 2'b00}));

   // R8: register 0 is never written
   a_r8_no_r0_write: assert property (@(posedge clk) disable iff (rst)
      rf_we |-> (rf_waddr != 5'd0));

   // R9: unrecognised words are silent
   a_r9_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
      !legal |-> (!rf_we && !dm_we));

   // R5: memory writes come only from stores
   a_r5_store_only: assert property (@(posedge clk) disable iff (rst)
      dm_we |-> (op == OP_SW));

   // R2: arithmetic targets rd
   a_r2_rtype_dest: assert property (@(posedge clk) disable iff (rst)
      (op == OP_RTYPE && (fn == FN_ADDU || fn == FN_SUBU) && rd != 5'd0) |->
      (rf_we && rf_waddr == rd));

   // R3: the OR-immediate targets rt
   a_r3_ori_dest: assert property (@(posedge clk) disable iff (rst)
      (op == OP_ORI && rt != 5'd0) |-> (rf_we && rf_waddr == rt));
endmodule

bind sc6_core sc6_core_chk u_chk (
   .clk      (clk),
   .rst      (rst),
   .op       (instr_o[31:26]),
   .rs       (instr_o[25:21]),
   .rt       (instr_o[20:16]),
   .rd       (instr_o[15:11]),
   .fn       (instr_o[5:0]),
   .imm      (instr_o[15:0]),
   .pc       (pc_o),
   .rf_we    (rf_we_o),
   .rf_waddr (rf_waddr_o),
   .dm_we    (dm_we_o)
);

// File: tb/sc6_core_tb.sv
module sc6_core_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ld_we = 1'b0;
   logic        ld_dmem = 1'b0;
   logic [5:0]  ld_addr = '0;
   logic [31:0] ld_data = '0;
   logic [31:0] pc_o, instr_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
   logic        rf_we_o, dm_we_o;
   logic [4:0]  rf_waddr_o;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   sc6_core u_dut (
      .clk(clk), .rst(rst), .ld_we(ld_we), .ld_dmem(ld_dmem), .ld_addr(ld_addr),
      .ld_data(ld_data), .pc_o(pc_o), .instr_o(instr_o), .rf_we_o(rf_we_o),
      .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o), .dm_we_o(dm_we_o),
      .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
   );

   // behavioural reference state
   logic [31:0] m_imem [64];
   logic [31:0] m_dmem [64];
   logic [31:0] m_reg  [32];
   logic [31:0] m_pc;

   function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
      return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction
   function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
      return {op, 5'(rs), 5'(rt), imm};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // one reference step: compare outputs of the current cycle, then advance state
   task automatic step_model();
      logic [31:0] ins, a, b, sx, zx, res, addr, npc;
      logic [5:0]  op, fn;
      int          rs, rt, rd, dest;
      bit          wr, st;
      string       tag;
      ins = m_imem[m_pc[7:2]];
      op = ins[31:26]; fn = ins[5:0];
      rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
      a = m_reg[rs]; b = m_reg[rt];
      sx = {{16{ins[15]}}, ins[15:0]};
      zx = {16'h0, ins[15:0]};
      wr = 0; st = 0; dest = 0; res = 0; addr = 0;
      npc = m_pc + 32'd4;
      tag = "R9";
      if (op == 6'h00 && fn == 6'h21) begin
         wr = 1; dest = rd; res = a + b; tag = "R2";
      end else if (op == 6'h00 && fn == 6'h23) begin
         wr = 1; dest = rd; res = a - b; tag = "R2";
      end else if (op == 6'h0D) begin
         wr = 1; dest = rt; res = a | zx; tag = "R3";
      end else if (op == 6'h23) begin
         addr = a + sx; wr = 1; dest = rt; res = m_dmem[addr[7:2]]; tag = "R4";
      end else if (op == 6'h2B) begin
         addr = a + sx; st = 1; tag = "R5";
      end else if (op == 6'h04) begin
         if (a == b) begin
            npc = m_pc + 32'd4 + (sx << 2); tag = "R6";
         end else tag = "R7";
      end
      if (wr && dest == 0) begin
         wr = 0; tag = "R8";
      end
      check("R10", instr_o, ins);
      check(tag, {31'd0, rf_we_o}, {31'd0, wr});
      if (wr) begin
         check(tag, {27'd0, rf_waddr_o}, 32'(dest));
         check(tag, rf_wdata_o, res);
      end
      check(tag, {31'd0, dm_we_o}, {31'd0, st});
      if (st) begin
         check("R5", dm_addr_o, addr);
         check("R5", dm_wdata_o, b);
      end
      if (wr) m_reg[dest] = res;
      if (st) m_dmem[addr[7:2]] = b;
      m_pc = npc;
   endtask

   initial begin
      for (int i = 0; i < 64; i++) begin
         m_imem[i] = '0;
         m_dmem[i] = 32'h5A5A_0000 | 32'(i);
      end
      for (int i = 0; i < 32; i++) m_reg[i] = '0;
      m_dmem[0] = 32'h1111_2222;
      m_dmem[1] = 32'h8000_0001;
      m_dmem[3] = 32'hDEAD_BEEF;
      m_imem[0]  = enc_i(6'h0D, 0, 1, 16'h0004);   // r1 = 4
      m_imem[1]  = enc_i(6'h0D, 0, 2, 16'hFFFF);   // r2 = 0xFFFF
      m_imem[2]  = enc_r(1, 2, 3, 6'h21);          // r3 = r1 + r2
      m_imem[3]  = enc_r(1, 2, 4, 6'h23);          // r4 = r1 - r2 (wraps)
      m_imem[4]  = enc_i(6'h23, 0, 5, 16'h0000);   // r5 = dm[0]
      m_imem[5]  = enc_i(6'h23, 1, 6, 16'h0008);   // r6 = dm[3]
      m_imem[6]  = enc_i(6'h23, 1, 7, 16'hFFFC);   // r7 = dm[0], negative offset
      m_imem[7]  = enc_i(6'h2B, 1, 3, 16'h0004);   // dm[2] = r3
      m_imem[8]  = enc_i(6'h23, 0, 8, 16'h0008);   // r8 = dm[2]
      m_imem[9]  = enc_i(6'h0D, 2, 0, 16'h1234);   // write to r0 dropped
      m_imem[10] = enc_r(0, 0, 9, 6'h21);          // r9 = r0 + r0
      m_imem[11] = {6'h3F, 26'h0};                 // unknown opcode
      m_imem[12] = enc_r(1, 2, 13, 6'h20);         // unknown funct
      m_imem[13] = enc_i(6'h04, 1, 2, 16'd5);      // not taken
      m_imem[14] = enc_i(6'h04, 5, 7, 16'd2);      // taken to word 17
      m_imem[15] = enc_i(6'h0D, 0, 10, 16'h0BAD);
      m_imem[16] = enc_i(6'h0D, 0, 10, 16'h0BAD);
      m_imem[17] = enc_r(2, 2, 11, 6'h23);         // r11 = 0
      m_imem[18] = enc_r(6, 6, 12, 6'h21);         // overflowing add
      m_imem[19] = enc_i(6'h04, 0, 0, 16'hFFFF);   // spin here
      m_pc = '0;

      repeat (2) @(posedge clk);
      for (int i = 0; i < 128; i++) begin
         @(negedge clk);
         ld_we = 1'b1; ld_dmem = (i >= 64); ld_addr = 6'(i % 64);
         ld_data = (i >= 64) ? m_dmem[i-64] : m_imem[i];
      end
      @(negedge clk);
      ld_we = 1'b0;
      @(posedge clk);
      #1;
      check("R1", pc_o, 32'd0);
      @(negedge clk);
      rst = 1'b0;
      #1;
      check("R1", pc_o, 32'd0);
      check("R1", rf_wdata_o, 32'h0000_0004);
      for (int c = 0; c < 30; c++) begin
         check((c > 0 && m_pc == 32'd68) ? "R6" : "R7", pc_o, m_pc);
         step_model();
         @(posedge clk);
         @(negedge clk);
         #1;
      end
      check("R6", pc_o, 32'd76);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R7 watchdog act=running exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule